// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a memory device. A four-wire style interface (test clock, mode select, serial data in and serial data out) walks the standard sixteen-state controller. The port selects one of three data paths through a small instruction register: a one-cell bypass path, a 32-bit identification word, or a chain of boundary cells. The boundary chain takes a parallel snapshot of the device pins. A separate output tells the pad ring to float the data pins while the active instruction calls for it.

There is no dedicated test-reset pin. The controller starts in Test-Logic-Reset from the power-on reset input, and it also returns there whenever mode select is held high for five clocks. Captures, shifts and updates happen on the rising test-clock edge. The serial output is retimed on the falling edge, so the receiving end can sample it on the next rising edge. The pull-ups that make undriven mode-select and data-in pins read as 1 belong to the pad cells outside this block.

Top module: `scan_tap_ctrl`

## Requirements
- R1: While `por_n` is low and on release, the controller sits in Test-Logic-Reset with instruction 3'b001 (identification) active, `tdo_en` low and `pins_hiz` low.
- R2: State moves follow the standard sixteen-state graph on each rising `tck`. Five consecutive cycles with `tms` high reach Test-Logic-Reset from any state, and that state reloads instruction 3'b001.
- R3: `tdo` and `tdo_en` change only on the falling `tck` edge. `tdo_en` is high only while the state is Shift-IR or Shift-DR, and `tdo` reads 0 whenever `tdo_en` is low.
- R4: Capture-IR loads 3'b001 into the instruction shifter, so a fixed 01 pattern sits in its low bits. The shifter moves LSB first, with `tdi` entering at the top. The new instruction takes effect only at Update-IR.
- R5: Instruction 3'b001 selects the 32-bit identification word. Bits 31:28 hold the revision, 27:18 the configuration, 17:12 vendor-defined bits, 11:1 the manufacturer code, and bit 0 is always 1. The word is loaded at Capture-DR and shifted out LSB first.
- R6: Codes 3'b011, 3'b110, 3'b111 and the reserved 3'b101 select the one-bit bypass cell. Capture-DR clears it, so the first bit shifted out is 0 and the following bits repeat `tdi` with one cycle of delay.
- R7: Code 3'b100 (sample) selects the boundary chain without floating the pins. Capture-DR loads `pin_in`, and cell 0 leaves first. After `BSR_LEN` shifts, the bits presented on `tdi` appear on `tdo`.
- R8: Codes 3'b000 (external test) and 3'b010 (sample with float) also select the boundary chain, and they hold `pins_hiz` high for as long as they are the active instruction.
- R9: The Pause and Exit states keep the selected register unchanged. Returning to Shift through Exit2 carries on the scan from the bit where it stopped, for both the data and instruction paths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tms | input | 1 | Test mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| pin_in | input | BSR_LEN | Parallel pin values captured by the boundary chain |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_en | output | 1 | Output driver enable for `tdo` |
| pins_hiz | output | 1 | Request to float the device data pins |

## Verification
A behavioural model in the bench tracks the controller state and every scan register, and it is compared with all three outputs at each falling edge. The identification word is shifted out past its length to show the fixed LSB, the field order, and `tdi` following behind it. Each of the four bypass codes is run with an alternating pattern, which separates a true one-cell path from a wrong path selection. The pin snapshot uses an irregular pattern, so a reversed or shifted chain shows up. Scans are paused in the middle, and five-high-`tms` escapes are made from deep states, to check that the contents are kept and that the return to the reset instruction works.

// File: rtl/scan_tap_pkg.sv
`timescale 1ns/1ps
package scan_tap_pkg;

   localparam int INSN_W = 3;

   typedef enum logic [3:0] {
      ST_TLR, ST_RTI,
      ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
      ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
   } tap_state_e;

   localparam logic [INSN_W-1:0] OP_EXTEST  = 3'b000;
   localparam logic [INSN_W-1:0] OP_IDCODE  = 3'b001;
   localparam logic [INSN_W-1:0] OP_SAMPLEZ = 3'b010;
   localparam logic [INSN_W-1:0] OP_BYPASS  = 3'b011;
   localparam logic [INSN_W-1:0] OP_SAMPLE  = 3'b100;

   typedef enum logic [1:0] {PATH_BYP, PATH_ID, PATH_BSR} dr_path_e;

   function automatic dr_path_e path_of(logic [INSN_W-1:0] op);
      case (op)
         OP_EXTEST, OP_SAMPLEZ, OP_SAMPLE: return PATH_BSR;
         OP_IDCODE:                        return PATH_ID;
         default:                          return PATH_BYP;
      endcase
   endfunction

   function automatic logic op_floats_pins(logic [INSN_W-1:0] op);
      return (op == OP_EXTEST) || (op == OP_SAMPLEZ);
   endfunction

endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
   import scan_tap_pkg::*;
(
   input  logic       tck,
   input  logic       por_n,
   input  logic       tms,
   output tap_state_e st
);

   tap_state_e nxt;

   always_comb begin
      case (st)
         ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
         ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
         ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
         ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
         ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
         ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
         ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
         ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
         ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
         ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
         ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
         ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
         ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
         ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
         ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
         default:   nxt = ST_TLR;
      endcase
   end

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) st <= ST_TLR;
      else        st <= nxt;
   end

   // R2: reset state is held while mode select stays high
   a_r2_tlr_hold: assert property (@(posedge tck) disable iff (!por_n)
      (st == ST_TLR && tms) |=> (st == ST_TLR));

   // R2: Capture-DR is reached only from Select-DR
   a_r2_capdr_entry: assert property (@(posedge tck) disable iff (!por_n)
      (st == ST_CAP_DR) |-> ($past(st) == ST_SEL_DR));

endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
module tap_ir
   import scan_tap_pkg::*;
(
   input  logic              tck,
   input  logic              por_n,
   input  logic              tdi,
   input  tap_state_e        st,
   output logic [INSN_W-1:0] ir_q,
   output logic              ir_so
);

   localparam logic [INSN_W-1:0] CAP_PAT = INSN_W'(2'b01);

   logic [INSN_W-1:0] sr;

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) begin
         sr   <= '0;
         ir_q <= OP_IDCODE;
      end else begin
         case (st)
            ST_CAP_IR: sr <= CAP_PAT;
            ST_SH_IR:  sr <= {tdi, sr[INSN_W-1:1]};
            default:   sr <= sr;
         endcase
         if (st == ST_TLR)         ir_q <= OP_IDCODE;
         else if (st == ST_UPD_IR) ir_q <= sr;
      end
   end

   assign ir_so = sr[0];

   // R4: the active instruction moves only at Update-IR or reset
   a_r4_ir_update_only: assert property (@(posedge tck) disable iff (!por_n)
      !$stable(ir_q) |-> ($past(st) == ST_UPD_IR || $past(st) == ST_TLR));

   // R1: Test-Logic-Reset leaves the identification instruction active
   a_r1_tlr_loads_id: assert property (@(posedge tck) disable iff (!por_n)
      (st == ST_TLR) |=> (ir_q == OP_IDCODE));

endmodule

// File: rtl/tap_dr.sv
`timescale 1ns/1ps
module tap_dr
   import scan_tap_pkg::*;
#(
   parameter int          BSR_LEN = 89,
   parameter logic [3:0]  ID_REV  = 4'h0,
   parameter logic [9:0]  ID_CFG  = 10'h124,
   parameter logic [5:0]  ID_VEND = 6'h00,
   parameter logic [10:0] ID_MFR  = 11'h2A5
)(
   input  logic               tck,
   input  logic               por_n,
   input  logic               tdi,
   input  tap_state_e         st,
   input  logic [INSN_W-1:0]  ir_q,
   input  logic [BSR_LEN-1:0] pin_in,
   output logic               dr_so
);

   localparam int          ID_W     = 32;
   localparam logic [ID_W-1:0] ID_VALUE = {ID_REV, ID_CFG, ID_VEND, ID_MFR, 1'b1};

   dr_path_e           path;
   logic               cap, sh;
   logic               byp;
   logic [ID_W-1:0]    id_sr;
   logic [BSR_LEN-1:0] bsr, bsr_shifted;

   assign path = path_of(ir_q);
   assign cap  = (st == ST_CAP_DR);
   assign sh   = (st == ST_SH_DR);

   generate
      if (BSR_LEN == 1) begin : g_bsr_single
         assign bsr_shifted = tdi;
      end else begin : g_bsr_chain
         assign bsr_shifted = {tdi, bsr[BSR_LEN-1:1]};
      end
   endgenerate

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) begin
         byp   <= 1'b0;
         id_sr <= '0;
         bsr   <= '0;
      end else begin
         if (path == PATH_BYP) begin
            if (cap)     byp <= 1'b0;
            else if (sh) byp <= tdi;
         end
         if (path == PATH_ID) begin
            if (cap)     id_sr <= ID_VALUE;
            else if (sh) id_sr <= {tdi, id_sr[ID_W-1:1]};
         end
         if (path == PATH_BSR) begin
            if (cap)     bsr <= pin_in;
            else if (sh) bsr <= bsr_shifted;
         end
      end
   end

   always_comb begin
      case (path)
         PATH_ID:  dr_so = id_sr[0];
         PATH_BSR: dr_so = bsr[0];
         default:  dr_so = byp;
      endcase
   end

   // R6: first bit out of the bypass cell after a capture is 0
   a_r6_byp_first_zero: assert property (@(posedge tck) disable iff (!por_n)
      (st == ST_SH_DR && $past(st) == ST_CAP_DR && path == PATH_BYP) |-> (dr_so == 1'b0));

   // R5: first bit out of the identification word is the fixed 1
   a_r5_id_lsb_one: assert property (@(posedge tck) disable iff (!por_n)
      (st == ST_SH_DR && $past(st) == ST_CAP_DR && path == PATH_ID) |-> (dr_so == 1'b1));

endmodule

// File: rtl/scan_tap_ctrl.sv
`timescale 1ns/1ps
module scan_tap_ctrl
   import scan_tap_pkg::*;
#(
   parameter int          BSR_LEN = 89,
   parameter logic [3:0]  ID_REV  = 4'h0,
   parameter logic [9:0]  ID_CFG  = 10'h124,
   parameter logic [5:0]  ID_VEND = 6'h00,
   parameter logic [10:0] ID_MFR  = 11'h2A5
)(
   input  logic               tck,
   input  logic               por_n,
   input  logic               tms,
   input  logic               tdi,
   input  logic [BSR_LEN-1:0] pin_in,
   output logic               tdo,
   output logic               tdo_en,
   output logic               pins_hiz
);

   generate
      if (BSR_LEN < 1) begin : g_bad_len
         $error("scan_tap_ctrl: BSR_LEN must be at least 1");
      end
   endgenerate

   tap_state_e        st;
   logic [INSN_W-1:0] ir_q;
   logic              ir_so, dr_so;

   tap_fsm u_fsm (.tck(tck), .por_n(por_n), .tms(tms), .st(st));

   tap_ir u_ir (.tck(tck), .por_n(por_n), .tdi(tdi), .st(st),
                .ir_q(ir_q), .ir_so(ir_so));

   tap_dr #(.BSR_LEN(BSR_LEN), .ID_REV(ID_REV), .ID_CFG(ID_CFG),
            .ID_VEND(ID_VEND), .ID_MFR(ID_MFR)) u_dr (
      .tck(tck), .por_n(por_n), .tdi(tdi), .st(st), .ir_q(ir_q),
      .pin_in(pin_in), .dr_so(dr_so));

   // serial output retimed on the falling edge
   always_ff @(negedge tck or negedge por_n) begin
      if (!por_n) begin
         tdo    <= 1'b0;
         tdo_en <= 1'b0;
      end else if (st == ST_SH_IR) begin
         tdo    <= ir_so;
         tdo_en <= 1'b1;
      end else if (st == ST_SH_DR) begin
         tdo    <= dr_so;
         tdo_en <= 1'b1;
      end else begin
         tdo    <= 1'b0;
         tdo_en <= 1'b0;
      end
   end

   assign pins_hiz = op_floats_pins(ir_q);

   // R3: driver enabled only while a shift state is current
   a_r3_en_only_shift: assert property (@(posedge tck) disable iff (!por_n)
      tdo_en |-> (st == ST_SH_IR || st == ST_SH_DR));

   // R8: pins stop floating once reset state has been visited
   a_r8_hiz_off_after_tlr: assert property (@(posedge tck) disable iff (!por_n)
      (st == ST_TLR) |=> !pins_hiz);

endmodule

// File: tb/scan_tap_ctrl_test.sv
`timescale 1ns/1ps
module scan_tap_ctrl_test;

   localparam int N = 89;
   localparam logic [31:0] EXP_ID = {4'h0, 10'h124, 6'h00, 11'h2A5, 1'b1};

   // reference state numbering (bench only)
   localparam int TLR = 0, RTI = 1, SDR = 2, CDR = 3, SHD = 4, E1D = 5, PD = 6, E2D = 7, UD = 8,
                  SIR = 9, CIR = 10, SHI = 11, E1I = 12, PI = 13, E2I = 14, UI = 15;

   logic tck = 1'b0, por_n = 1'b0, tms = 1'b1, tdi = 1'b1;
   logic [N-1:0] pins;
   logic tdo, tdo_en, pins_hiz;

   scan_tap_ctrl uut (.tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .pin_in(pins),
                      .tdo(tdo), .tdo_en(tdo_en), .pins_hiz(pins_hiz));

   always #2.5 tck = ~tck;

   int vectors = 0, miscompares = 0;
   string cur_req = "R1";
   bit done = 0;

   int m_st = TLR;
   logic [2:0] m_ir = 3'b001, m_sr = 3'b000;
   logic m_byp = 1'b0;
   logic [31:0] m_id = '0;
   logic [N-1:0] m_bsr = '0;
   logic last_tdo = 1'b0, last_en = 1'b0;

   function automatic int path(logic [2:0] op);
      if (op == 3'b000 || op == 3'b010 || op == 3'b100) return 2;
      if (op == 3'b001) return 1;
      return 0;
   endfunction

   task automatic fail(string what, logic a, logic e);
      miscompares++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", cur_req, what, a, e, $time);
   endtask

   task automatic model_edge(logic t, logic d);
      int p = path(m_ir);
      int ns;
      case (m_st)
         CIR: m_sr = 3'b001;
         SHI: m_sr = {d, m_sr[2:1]};
         UI:  m_ir = m_sr;
         TLR: m_ir = 3'b001;
         CDR: begin
            if (p == 0) m_byp = 1'b0; else if (p == 1) m_id = EXP_ID; else m_bsr = pins;
         end
         SHD: begin
            if (p == 0) m_byp = d;
            else if (p == 1) m_id = {d, m_id[31:1]};
            else m_bsr = {d, m_bsr[N-1:1]};
         end
         default: ;
      endcase
      case (m_st)
         TLR: ns = t ? TLR : RTI;   RTI: ns = t ? SDR : RTI;
         SDR: ns = t ? SIR : CDR;   CDR: ns = t ? E1D : SHD;
         SHD: ns = t ? E1D : SHD;   E1D: ns = t ? UD  : PD;
         PD:  ns = t ? E2D : PD;    E2D: ns = t ? UD  : SHD;
         UD:  ns = t ? SDR : RTI;   SIR: ns = t ? TLR : CIR;
         CIR: ns = t ? E1I : SHI;   SHI: ns = t ? E1I : SHI;
         E1I: ns = t ? UI  : PI;    PI:  ns = t ? E2I : PI;
         E2I: ns = t ? UI  : SHI;   default: ns = t ? SDR : RTI;
      endcase
      m_st = ns;
   endtask

   task automatic compare();
      logic e_en, e_tdo, e_hiz;
      int p = path(m_ir);
      e_en  = (m_st == SHI || m_st == SHD);
      e_tdo = 1'b0;
      if (m_st == SHI) e_tdo = m_sr[0];
      if (m_st == SHD) e_tdo = (p == 0) ? m_byp : (p == 1) ? m_id[0] : m_bsr[0];
      e_hiz = (m_ir == 3'b000 || m_ir == 3'b010);
      vectors++;
      if (tdo_en !== e_en) fail("tdo_en", tdo_en, e_en);
      else if (tdo !== e_tdo) fail("tdo", tdo, e_tdo);
      else if (pins_hiz !== e_hiz) fail("pins_hiz", pins_hiz, e_hiz);
      last_tdo = tdo;
      last_en  = tdo_en;
   endtask

   // one TCK cycle; called just after a falling-edge sample
   task automatic step(logic t, logic d);
      tms = t; tdi = d;
      @(posedge tck);
      model_edge(t, d);
      #1;
      vectors++;  // R3: nothing on tdo moves at the rising edge
      if (tdo !== last_tdo || tdo_en !== last_en) begin
         miscompares++;
         $display("FAIL R3 output moved at rising edge actual=%0b/%0b expected=%0b/%0b",
                  tdo, tdo_en, last_tdo, last_en);
      end
      @(negedge tck); #1;
      compare();
   endtask

   task automatic load_ir(logic [2:0] op);
      step(1, 0); step(1, 0); step(0, 0); step(0, 0);
      for (int i = 0; i < 3; i++) step(i == 2, op[i]);
      step(1, 0); step(0, 0);
   endtask

   task automatic scan_dr(int n, int seed);
      step(1, 0); step(0, 0); step(0, 0);
      for (int i = 0; i < n; i++) step(i == n - 1, ((i * seed) % 5) < 2);
      step(1, 0); step(0, 0);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
   endtask

   initial begin
      for (int i = 0; i < N; i++) pins[i] = ((i * 7) % 3 == 0) ^ (i > 60);
      // R1: during reset
      repeat (3) @(negedge tck);
      #1; compare();
      por_n = 1'b1;
      step(1, 1);                       // R1: stays in reset state after release
      cur_req = "R5"; step(0, 0); scan_dr(40, 3);
      cur_req = "R4"; load_ir(3'b011);  // capture pattern checked while shifting
      cur_req = "R6"; scan_dr(12, 1);
      load_ir(3'b101); scan_dr(8, 2);
      load_ir(3'b110); scan_dr(8, 3);
      load_ir(3'b111); scan_dr(8, 4);
      cur_req = "R7"; load_ir(3'b100); scan_dr(N + 10, 3);
      for (int i = 0; i < N; i++) pins[i] = ~pins[i];
      scan_dr(N + 2, 7);
      cur_req = "R8"; load_ir(3'b000); scan_dr(20, 1);
      load_ir(3'b010); scan_dr(N + 3, 2);
      cur_req = "R9"; load_ir(3'b001);
      step(1, 0); step(0, 0); step(0, 0);
      for (int i = 0; i < 5; i++) step(i == 4, i[0]);
      step(0, 0); step(0, 0); step(1, 0); step(0, 0);
      for (int i = 0; i < 10; i++) step(i == 9, 1);
      step(1, 0); step(0, 0);
      // instruction path paused mid-scan
      step(1, 0); step(1, 0); step(0, 0); step(0, 0);
      step(1, 0); step(0, 0); step(0, 0); step(1, 0); step(0, 0);
      step(0, 0); step(1, 0); step(1, 0); step(0, 0);
      cur_req = "R2"; load_ir(3'b000);
      step(1, 0); step(0, 0); step(0, 0); step(0, 1);
      for (int i = 0; i < 5; i++) step(1, 0);
      step(0, 0); scan_dr(34, 5);
      load_ir(3'b010); step(1, 0); step(1, 0); step(0, 0); step(0, 0);
      for (int i = 0; i < 5; i++) step(1, 1);
      step(0, 0); step(1, 0); step(0, 0); step(1, 0);
      step(0, 0); step(1, 0); step(1, 0); step(1, 0);
      step(0, 0);
      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge tck);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         summary();
         $finish;
      end
   end

endmodule